// File: doc/BRIEF.md
# Programmable Channel Stream Interleaver

This block merges six independent, low-rate channel sample streams into a smaller number of higher-rate output streams by plain time multiplexing. Each input channel delivers an I/Q sample pair with a valid strobe whenever it has a new sample. A 4-bit stream control code selects one of ten fixed ways to group adjacent channels. Each group's samples leave on a single output stream, so the output rate of a group equals the sum of its members' rates. Every output sample carries a tag that names the channel it came from.

Each group is emitted on the output index of its lowest-numbered channel. Output indices that are absorbed into a group stay idle and are flagged inactive. The block also reports how many output streams are in use, so downstream gain and port logic can skip unused streams. If several channels of one group deliver samples in the same cycle, a two-entry holding buffer per channel keeps them. They then leave one per cycle in ascending channel order. The control code is captured while reset is asserted and at frame boundaries, and at no other time.

Top module: `ilv_stream_merge`

## Requirements
- R1: Stream control codes map to groups of adjacent channels as follows: 0 gives {0,1},2,3,4,5; 1 gives {0,1,2},3,4,5; 2 gives {0..3},4,5; 3 gives {0..4},5; 4 gives {0..5}; 5 gives {0,1,2},{3,4,5}; 6 gives {0,1},{2,3},{4,5}; 7 gives {0,1},{2,3},4,5; 8 gives {0,1,2},{3,4},5; 9 gives {0..3},{4,5}.
- R2: Codes 10 to 15 leave all six channels independent, and the active stream count is 6.
- R3: `st_active` bit k is 1 exactly when channel k is the lowest channel of its group. `st_count` equals the number of groups.
- R4: A sample from channel c leaves on output index L, where L is the lowest channel of c's group. Outputs whose `st_active` bit is 0 never assert valid.
- R5: Samples that arrive together from channels of one group leave one per cycle in ascending channel order, and none is lost or repeated.
- R6: Each output sample carries the source channel number in its 3-bit tag (channel index k occupies `st_tag[3k+2:3k]`), with its I and Q values unchanged.
- R7: A lone sample whose valid is sampled at clock edge E appears on the output after edge E+1 and not after edge E.
- R8: `stream_ctrl` is captured only on an edge where `frame_start` or `rst` is high. Changes at any other time have no effect on grouping, `st_active` or `st_count`.
- R9: While reset is asserted, and until a sample is delivered afterwards, all output valids are low. Samples presented during reset are discarded.
- R10: No holding buffer ever overflows, provided each channel delivers at most one sample in any six consecutive cycles.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous active-high reset; also captures `stream_ctrl` |
| frame_start | input | 1 | Frame boundary strobe; captures `stream_ctrl` |
| stream_ctrl | input | 4 | Grouping selection code |
| ch_valid | input | 6 | Per-channel sample strobe, bit c for channel c |
| ch_i | input | 6*DATA_W | In-phase samples, channel c at slice c |
| ch_q | input | 6*DATA_W | Quadrature samples, channel c at slice c |
| st_valid | output | 6 | Per-output-stream valid |
| st_i | output | 6*DATA_W | In-phase output per stream |
| st_q | output | 6*DATA_W | Quadrature output per stream |
| st_tag | output | 18 | Source channel tag per stream, 3 bits each |
| st_active | output | 6 | Output stream in use mask |
| st_count | output | 3 | Number of active output streams |

## Verification
The assertions take the input rate limit for granted: no channel strobes valid more than once in six cycles, and the control code moves only with a frame strobe or under reset while no samples are pending. The stimulus keeps within this in two ways. It fires all six channels together only once per eight-cycle burst window. Single-channel probes touch each channel once per pass. It changes `stream_ctrl` without a frame strobe only after the buffers have drained, so that what it observes is the ignored change and nothing else.

// File: rtl/ilv_pkg.sv
package ilv_pkg;
  localparam int NCH    = 6;
  localparam int TAG_W  = 3;
  localparam int CNT_W  = 3;
  localparam int CODE_W = 4;

  typedef logic [TAG_W-1:0] chan_tag_t;

  // bit c set: channel c opens a new group
  function automatic logic [NCH-1:0] group_heads(input logic [CODE_W-1:0] code);
    case (code)
      4'd0:    return 6'b111101;
      4'd1:    return 6'b111001;
      4'd2:    return 6'b110001;
      4'd3:    return 6'b100001;
      4'd4:    return 6'b000001;
      4'd5:    return 6'b001001;
      4'd6:    return 6'b010101;
      4'd7:    return 6'b110101;
      4'd8:    return 6'b101001;
      4'd9:    return 6'b010001;
      default: return 6'b111111;
    endcase
  endfunction

  function automatic logic [CNT_W-1:0] stream_total(input logic [CODE_W-1:0] code);
    case (code)
      4'd0:    return 3'd5;
      4'd1:    return 3'd4;
      4'd2:    return 3'd3;
      4'd3:    return 3'd2;
      4'd4:    return 3'd1;
      4'd5:    return 3'd2;
      4'd6:    return 3'd3;
      4'd7:    return 3'd4;
      4'd8:    return 3'd3;
      4'd9:    return 3'd2;
      default: return 3'd6;
    endcase
  endfunction
endpackage

// File: rtl/ilv_group_decode.sv
module ilv_group_decode
  import ilv_pkg::*;
(
  input  logic                   clk,
  input  logic                   rst,
  input  logic                   frame_start,
  input  logic [CODE_W-1:0]      ctrl_code,
  output logic [NCH-1:0]         heads_q,
  output logic [CNT_W-1:0]       count_q,
  output logic [NCH*TAG_W-1:0]   leader_q
);
  logic [NCH-1:0]       heads_d;
  logic [NCH*TAG_W-1:0] leader_d;
  chan_tag_t            cur;

  always_comb begin
    heads_d  = group_heads(ctrl_code);
    cur      = '0;
    leader_d = '0;
    for (int c = 0; c < NCH; c++) begin
      if (heads_d[c]) cur = TAG_W'(c);
      leader_d[c*TAG_W +: TAG_W] = cur;
    end
  end

  // capture under reset or at a frame boundary only
  always_ff @(posedge clk) begin
    if (rst || frame_start) begin
      heads_q  <= heads_d;
      count_q  <= stream_total(ctrl_code);
      leader_q <= leader_d;
    end
  end

  assert_cfg_hold_R8: assert property (@(posedge clk) disable iff (rst)
    (!$past(frame_start) && !$past(rst)) |-> ($stable(heads_q) && $stable(count_q)));

  assert_count_match_R3: assert property (@(posedge clk) disable iff (rst)
    count_q == CNT_W'($countones(heads_q)));

  assert_head_zero_R1: assert property (@(posedge clk) disable iff (rst)
    heads_q[0]);
endmodule

// File: rtl/ilv_chan_fifo.sv
module ilv_chan_fifo #(
  parameter int WIDTH = 32,
  parameter int DEPTH = 2
) (
  input  logic             clk,
  input  logic             rst,
  input  logic             push,
  input  logic [WIDTH-1:0] push_data,
  input  logic             pop,
  output logic [WIDTH-1:0] pop_data,
  output logic             empty
);
  localparam int PTR_W = (DEPTH > 1) ? $clog2(DEPTH) : 1;
  localparam int CNT_W = $clog2(DEPTH + 1);

  logic [WIDTH-1:0] mem [DEPTH];
  logic [PTR_W-1:0] wr_ptr, rd_ptr;
  logic [CNT_W-1:0] cnt;

  function automatic logic [PTR_W-1:0] bump(input logic [PTR_W-1:0] p);
    return (p == PTR_W'(DEPTH - 1)) ? '0 : p + 1'b1;
  endfunction

  always_ff @(posedge clk) begin
    if (push) mem[wr_ptr] <= push_data;
  end

  always_ff @(posedge clk) begin
    if (rst) begin
      wr_ptr <= '0;
      rd_ptr <= '0;
      cnt    <= '0;
    end else begin
      if (push) wr_ptr <= bump(wr_ptr);
      if (pop)  rd_ptr <= bump(rd_ptr);
      cnt <= cnt + CNT_W'(push) - CNT_W'(pop);
    end
  end

  assign pop_data = mem[rd_ptr];
  assign empty    = (cnt == '0);

  assert_no_overflow_R10: assert property (@(posedge clk) disable iff (rst)
    (push && !pop) |-> (cnt != CNT_W'(DEPTH)));

  assert_pop_nonempty_R5: assert property (@(posedge clk) disable iff (rst)
    pop |-> !empty);
endmodule

// File: rtl/ilv_out_arb.sv
module ilv_out_arb #(
  parameter int N = 6
) (
  input  logic [N-1:0] req,
  output logic [N-1:0] grant
);
  logic found;

  // lowest requesting index wins
  always_comb begin
    grant = '0;
    found = 1'b0;
    for (int c = 0; c < N; c++) begin
      if (req[c] && !found) begin
        grant[c] = 1'b1;
        found    = 1'b1;
      end
    end
  end

  always_comb begin
    assert_grant_onehot_R5: assert ($onehot0(grant));
    assert_grant_subset_R5: assert ((grant & ~req) == '0);
  end
endmodule

// File: rtl/ilv_stream_merge.sv
module ilv_stream_merge
  import ilv_pkg::*;
#(
  parameter int DATA_W     = 16,
  parameter int HOLD_DEPTH = 2
) (
  input  logic                    clk,
  input  logic                    rst,
  input  logic                    frame_start,
  input  logic [CODE_W-1:0]       stream_ctrl,
  input  logic [NCH-1:0]          ch_valid,
  input  logic [NCH*DATA_W-1:0]   ch_i,
  input  logic [NCH*DATA_W-1:0]   ch_q,
  output logic [NCH-1:0]          st_valid,
  output logic [NCH*DATA_W-1:0]   st_i,
  output logic [NCH*DATA_W-1:0]   st_q,
  output logic [NCH*TAG_W-1:0]    st_tag,
  output logic [NCH-1:0]          st_active,
  output logic [CNT_W-1:0]        st_count
);
  localparam int PAY_W = 2 * DATA_W;

  logic [NCH-1:0]       heads_q;
  logic [CNT_W-1:0]     count_q;
  logic [NCH*TAG_W-1:0] leader_flat;

  ilv_group_decode u_decode (
    .clk         (clk),
    .rst         (rst),
    .frame_start (frame_start),
    .ctrl_code   (stream_ctrl),
    .heads_q     (heads_q),
    .count_q     (count_q),
    .leader_q    (leader_flat)
  );

  logic [PAY_W-1:0] pay   [NCH];
  logic [NCH-1:0]   empty;
  logic [NCH-1:0]   pop;

  for (genvar c = 0; c < NCH; c++) begin : g_hold
    ilv_chan_fifo #(.WIDTH(PAY_W), .DEPTH(HOLD_DEPTH)) u_fifo (
      .clk       (clk),
      .rst       (rst),
      .push      (ch_valid[c]),
      .push_data ({ch_i[c*DATA_W +: DATA_W], ch_q[c*DATA_W +: DATA_W]}),
      .pop       (pop[c]),
      .pop_data  (pay[c]),
      .empty     (empty[c])
    );
  end

  logic [NCH-1:0] req   [NCH];
  logic [NCH-1:0] grant [NCH];

  always_comb begin
    for (int k = 0; k < NCH; k++) begin
      for (int c = 0; c < NCH; c++) begin
        req[k][c] = (leader_flat[c*TAG_W +: TAG_W] == TAG_W'(k)) && !empty[c];
      end
    end
  end

  for (genvar k = 0; k < NCH; k++) begin : g_arb
    ilv_out_arb #(.N(NCH)) u_arb (
      .req   (req[k]),
      .grant (grant[k])
    );
  end

  logic [NCH-1:0]   sel_valid;
  logic [PAY_W-1:0] sel_pay [NCH];
  chan_tag_t        sel_tag [NCH];

  always_comb begin
    pop = '0;
    for (int k = 0; k < NCH; k++) begin
      pop          = pop | grant[k];
      sel_valid[k] = |grant[k];
      sel_pay[k]   = '0;
      sel_tag[k]   = '0;
      for (int c = 0; c < NCH; c++) begin
        if (grant[k][c]) begin
          sel_pay[k] = pay[c];
          sel_tag[k] = TAG_W'(c);
        end
      end
    end
  end

  always_ff @(posedge clk) begin
    if (rst) begin
      st_valid <= '0;
      st_i     <= '0;
      st_q     <= '0;
      st_tag   <= '0;
    end else begin
      st_valid <= sel_valid;
      for (int k = 0; k < NCH; k++) begin
        if (sel_valid[k]) begin
          st_i[k*DATA_W +: DATA_W]  <= sel_pay[k][PAY_W-1 -: DATA_W];
          st_q[k*DATA_W +: DATA_W]  <= sel_pay[k][DATA_W-1:0];
          st_tag[k*TAG_W +: TAG_W]  <= sel_tag[k];
        end
      end
    end
  end

  assign st_active = heads_q;
  assign st_count  = count_q;

  assert_absorbed_idle_R4: assert property (@(posedge clk) disable iff (rst)
    (st_valid & ~st_active) == '0);

  for (genvar k = 0; k < NCH; k++) begin : g_chk
    assert_tag_range_R6: assert property (@(posedge clk) disable iff (rst)
      st_valid[k] |-> (st_tag[k*TAG_W +: TAG_W] >= TAG_W'(k)));
  end
endmodule

// File: tb/ilv_stream_merge_tb_top.sv
`timescale 1ns/1ps
module ilv_stream_merge_tb_top;
  import ilv_pkg::*;
  localparam int W = 16;

  logic clk = 1'b0;
  always #2 clk = ~clk;

  logic                rst;
  logic                frame_start;
  logic [CODE_W-1:0]   stream_ctrl;
  logic [NCH-1:0]      ch_valid;
  logic [NCH*W-1:0]    ch_i, ch_q;
  logic [NCH-1:0]      st_valid;
  logic [NCH*W-1:0]    st_i, st_q;
  logic [NCH*TAG_W-1:0] st_tag;
  logic [NCH-1:0]      st_active;
  logic [CNT_W-1:0]    st_count;

  ilv_stream_merge #(.DATA_W(W), .HOLD_DEPTH(2)) dut_i (
    .clk(clk), .rst(rst), .frame_start(frame_start), .stream_ctrl(stream_ctrl),
    .ch_valid(ch_valid), .ch_i(ch_i), .ch_q(ch_q),
    .st_valid(st_valid), .st_i(st_i), .st_q(st_q), .st_tag(st_tag),
    .st_active(st_active), .st_count(st_count)
  );

  int checks = 0;
  int fails  = 0;
  bit done   = 0;
  int lead [NCH];

  task automatic chk(input bit ok, input string req, input logic [31:0] act, input logic [31:0] exp);
    checks++;
    if (!ok) begin
      fails++;
      $display("FAIL %s actual=%0h expected=%0h", req, act, exp);
    end
  endtask

  // group sizes, first group in the low nibble
  function automatic logic [23:0] sizes_of(input int code);
    case (code)
      0: return 24'h11112;  1: return 24'h1113;  2: return 24'h114;
      3: return 24'h15;     4: return 24'h6;     5: return 24'h33;
      6: return 24'h222;    7: return 24'h1122;  8: return 24'h123;
      9: return 24'h24;     default: return 24'h111111;
    endcase
  endfunction

  task automatic load_expect(input int code);
    logic [23:0] s = sizes_of(code);
    int pos = 0;
    while (s != 0) begin
      int g = int'(s[3:0]);
      for (int j = 0; j < g; j++) lead[pos + j] = pos;
      pos += g;
      s = s >> 4;
    end
  endtask

  function automatic logic [W-1:0] mk_i(input int code, input int c, input int n);
    return W'(code * 256 + n * 16 + c + 1);
  endfunction

  task automatic check_cfg(input string req);
    logic [NCH-1:0] m = '0;
    int cnt = 0;
    for (int c = 0; c < NCH; c++) if (lead[c] == c) begin m[c] = 1'b1; cnt++; end
    chk(st_active == m, {req, " active mask"}, 32'(st_active), 32'(m));
    chk(st_count == CNT_W'(cnt), {req, " stream count"}, 32'(st_count), 32'(cnt));
  endtask

  task automatic apply_code(input int code);
    @(negedge clk);
    stream_ctrl = CODE_W'(code);
    frame_start = 1'b1;
    @(negedge clk);
    frame_start = 1'b0;
    load_expect(code);
    check_cfg(code > 9 ? "R2 R3" : "R1 R3");
  endtask

  task automatic burst(input int code);
    @(negedge clk);
    ch_valid = '1;
    for (int c = 0; c < NCH; c++) begin
      ch_i[c*W +: W] = mk_i(code, c, 0);
      ch_q[c*W +: W] = ~mk_i(code, c, 0);
    end
    @(negedge clk);
    ch_valid = '0;
    chk(st_valid == '0, "R7 burst early", 32'(st_valid), 0);
    for (int j = 0; j < NCH; j++) begin
      @(negedge clk);
      for (int k = 0; k < NCH; k++) begin
        int m = -1;
        int seen = 0;
        if (lead[k] == k) begin
          for (int c = k; c < NCH; c++) begin
            if (lead[c] == k) begin
              if (seen == j) m = c;
              seen++;
            end
          end
        end
        if (m < 0) begin
          chk(st_valid[k] == 1'b0, "R4 R5 idle output", 32'(st_valid[k]), 0);
        end else begin
          chk(st_valid[k] == 1'b1, "R1 R5 merged valid", 32'(st_valid[k]), 1);
          chk(st_tag[k*TAG_W +: TAG_W] == TAG_W'(m), "R5 R6 ascending tag",
              32'(st_tag[k*TAG_W +: TAG_W]), 32'(m));
          chk(st_i[k*W +: W] == mk_i(code, m, 0) && st_q[k*W +: W] == ~mk_i(code, m, 0),
              "R6 payload", 32'(st_i[k*W +: W]), 32'(mk_i(code, m, 0)));
        end
      end
    end
    @(negedge clk);
    chk(st_valid == '0, "R5 no extra samples", 32'(st_valid), 0);
  endtask

  task automatic single(input int code, input int c);
    logic [NCH-1:0] e = '0;
    @(negedge clk);
    ch_valid[c] = 1'b1;
    ch_i[c*W +: W] = mk_i(code, c, 1);
    ch_q[c*W +: W] = ~mk_i(code, c, 1);
    @(negedge clk);
    ch_valid = '0;
    chk(st_valid == '0, "R7 not after first edge", 32'(st_valid), 0);
    @(negedge clk);
    e[lead[c]] = 1'b1;
    chk(st_valid == e, "R4 R7 R8 routing", 32'(st_valid), 32'(e));
    chk(st_tag[lead[c]*TAG_W +: TAG_W] == TAG_W'(c), "R6 tag",
        32'(st_tag[lead[c]*TAG_W +: TAG_W]), 32'(c));
    chk(st_i[lead[c]*W +: W] == mk_i(code, c, 1) && st_q[lead[c]*W +: W] == ~mk_i(code, c, 1),
        "R6 single payload", 32'(st_i[lead[c]*W +: W]), 32'(mk_i(code, c, 1)));
  endtask

  initial begin
    rst = 1'b1;
    frame_start = 1'b0;
    stream_ctrl = 4'd6;
    ch_valid = '1;
    ch_i = '1;
    ch_q = '0;
    repeat (3) @(negedge clk);
    load_expect(6);
    check_cfg("R8 capture under reset");
    chk(st_valid == '0, "R9 reset valid", 32'(st_valid), 0);
    rst = 1'b0;
    ch_valid = '0;
    @(negedge clk);
    chk(st_valid == '0, "R9 reset discards samples", 32'(st_valid), 0);
    @(negedge clk);
    chk(st_valid == '0, "R9 reset buffers empty", 32'(st_valid), 0);
    for (int code = 0; code < 16; code++) begin
      apply_code(code);
      burst(code);
      stream_ctrl = ~CODE_W'(code);
      repeat (2) @(negedge clk);
      check_cfg("R8 ignored change");
      for (int c = 0; c < NCH; c++) single(code, c);
    end
    done = 1'b1;
    $display("TB_RESULT checks=%0d failures=%0d", checks, fails);
    $finish;
  end

  initial begin
    repeat (200000) @(posedge clk);
    if (!done) begin
      checks++;
      fails++;
      $display("FAIL watchdog actual=running expected=finished");
      $display("TB_RESULT checks=%0d failures=%0d", checks, fails);
      $finish;
    end
  end
endmodule